// File: doc/BRIEF.md
# Multi-Channel Capture Trigger Unit

This block watches a sampled input bus, one sample per clock, and produces a single trigger event once the conditions it holds are all met. Level conditions can be placed on any number of channels. A mask picks the channels that are compared, and a value word gives the level each compared channel must show. On top of the levels, one edge condition can be enabled. It looks at one channel, chosen by index, for a rising, falling or either-direction transition.

A capture controller arms the unit with a one-cycle `arm` strobe. From the next sample on, the unit evaluates every sample. The first sample that satisfies the enabled conditions produces a one-clock `trig_pulse` and sets the sticky `triggered` flag. The unit then stops watching until it is armed again. The configuration inputs are expected to be held static while the unit is armed.

Top module: `trig_unit`

## Requirements
- R1: While `rst` is high, and after it is released, `trig_pulse`, `triggered` and `armed` are all 0 until the next arm.
- R2: A clock edge with `arm` high sets `armed` and clears `triggered`. The sample present in that cycle is neither evaluated nor kept as the previous sample. Arming while already armed restarts the edge history.
- R3: A channel whose `lvl_mask` bit is 1 matches only when its sample bit equals the same bit of `lvl_val`. A channel whose mask bit is 0 is ignored.
- R4: The edge channel is `smp[edge_sel]`. `edge_pol` encodes the direction: 2'b00 is a rising edge (0 then 1), 2'b01 is a falling edge (1 then 0), and 2'b10 or 2'b11 is either change. The edge compares the current sample with the previous one.
- R5: The first sample after arming cannot produce an edge, whatever the sample taken in the arm cycle was.
- R6: With `edge_en` high, the trigger fires only on a sample where the edge occurs and all enabled level conditions hold together.
- R7: With `edge_en` low, the trigger fires on the first sample after arming on which all enabled level conditions hold. With no level bit and no edge enabled, that is the first sample after arming.
- R8: The firing sample taken at clock edge k makes `trig_pulse` high from edge k to edge k+1 only. In the same cycle `triggered` becomes 1 and `armed` becomes 0.
- R9: An unarmed unit never fires. Once fired, `triggered` stays 1 and later matching samples cause no pulse until the unit is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle arm / re-arm strobe |
| smp | input | 16 | Sampled channel bus |
| lvl_mask | input | 16 | Channels that carry a level condition |
| lvl_val | input | 16 | Required level of each masked channel |
| edge_en | input | 1 | Enables the single edge condition |
| edge_sel | input | 4 | Index of the edge channel |
| edge_pol | input | 2 | Edge direction code |
| trig_pulse | output | 1 | One-cycle trigger event |
| triggered | output | 1 | Sticky flag, set on fire and cleared by arm |
| armed | output | 1 | Unit is waiting for its conditions |

## Verification
The hardest case to reach from the ports is the edge history across an arm. A transition that runs from the arm-cycle sample, or from a sample taken before a re-arm, into the first evaluated sample must not count as an edge. The stimulus puts the opposite level on the edge channel during the arm cycle, and also re-arms in the middle of a watch, so a design that keeps stale history would fire one sample early. Other sequences fire on a rising edge while a level condition fails, and then again while it holds. This separates the AND of the edge with the levels from either condition alone.

// File: rtl/trig_pkg.sv
package trig_pkg;

    localparam int unsigned DEF_CH = 16;

    localparam logic [1:0] POL_RISE = 2'b00;
    localparam logic [1:0] POL_FALL = 2'b01;

    typedef struct packed {
        logic armed;
        logic triggered;
        logic pulse;
    } trig_state_t;

    // Direction check on one channel between two successive samples.
    function automatic logic edge_seen(input logic [1:0] pol,
                                       input logic       old_b,
                                       input logic       new_b);
        case (pol)
            POL_RISE: edge_seen = !old_b && new_b;
            POL_FALL: edge_seen = old_b && !new_b;
            default:  edge_seen = old_b ^ new_b;
        endcase
    endfunction

endpackage

// File: rtl/trig_level_match.sv
module trig_level_match #(
    parameter int unsigned CH = 16
) (
    input  logic [CH-1:0] smp,
    input  logic [CH-1:0] mask,
    input  logic [CH-1:0] val,
    output logic          lvl_ok
);
    logic [CH-1:0] ch_ok;

    for (genvar i = 0; i < CH; i++) begin : g_ch
        assign ch_ok[i] = !mask[i] || (smp[i] == val[i]);
    end

    assign lvl_ok = &ch_ok;
endmodule

// File: rtl/trig_edge_detect.sv
module trig_edge_detect
    import trig_pkg::*;
#(
    parameter int unsigned CH    = 16,
    localparam int unsigned IDX_W = (CH > 1) ? $clog2(CH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             armed,
    input  logic [CH-1:0]    smp,
    input  logic [IDX_W-1:0] sel,
    input  logic [1:0]       pol,
    output logic             hit
);
    logic [CH-1:0] prev_q;
    logic          prev_vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q     <= '0;
            prev_vld_q <= 1'b0;
        end else if (arm) begin
            prev_vld_q <= 1'b0;
        end else if (armed) begin
            prev_q     <= smp;
            prev_vld_q <= 1'b1;
        end
    end

    assign hit = prev_vld_q && edge_seen(pol, prev_q[sel], smp[sel]);
endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
    import trig_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic lvl_ok,
    input  logic edge_en,
    input  logic edge_hit,
    output logic armed,
    output logic triggered,
    output logic pulse
);
    trig_state_t st_q;
    logic        fire;

    assign fire = st_q.armed && !arm && lvl_ok && (!edge_en || edge_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (arm) begin
            st_q.armed     <= 1'b1;
            st_q.triggered <= 1'b0;
            st_q.pulse     <= 1'b0;
        end else if (fire) begin
            st_q.armed     <= 1'b0;
            st_q.triggered <= 1'b1;
            st_q.pulse     <= 1'b1;
        end else begin
            st_q.pulse <= 1'b0;
        end
    end

    assign armed     = st_q.armed;
    assign triggered = st_q.triggered;
    assign pulse     = st_q.pulse;
endmodule

// File: rtl/trig_unit.sv
module trig_unit #(
    parameter int unsigned CH    = 16,
    localparam int unsigned IDX_W = (CH > 1) ? $clog2(CH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [CH-1:0]    smp,
    input  logic [CH-1:0]    lvl_mask,
    input  logic [CH-1:0]    lvl_val,
    input  logic             edge_en,
    input  logic [IDX_W-1:0] edge_sel,
    input  logic [1:0]       edge_pol,
    output logic             trig_pulse,
    output logic             triggered,
    output logic             armed
);
    logic lvl_ok;
    logic edge_hit;

    trig_level_match #(.CH(CH)) u_lvl (
        .smp    (smp),
        .mask   (lvl_mask),
        .val    (lvl_val),
        .lvl_ok (lvl_ok)
    );

    trig_edge_detect #(.CH(CH)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .arm   (arm),
        .armed (armed),
        .smp   (smp),
        .sel   (edge_sel),
        .pol   (edge_pol),
        .hit   (edge_hit)
    );

    trig_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .lvl_ok    (lvl_ok),
        .edge_en   (edge_en),
        .edge_hit  (edge_hit),
        .armed     (armed),
        .triggered (triggered),
        .pulse     (trig_pulse)
    );
endmodule

// File: rtl/trig_unit_chk.sv
module trig_unit_chk (
    input logic clk,
    input logic rst,
    input logic arm,
    input logic edge_en,
    input logic trig_pulse,
    input logic triggered,
    input logic armed
);
    logic arm_q;

    always_ff @(posedge clk) begin
        if (rst) arm_q <= 1'b0;
        else     arm_q <= arm;
    end

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |=> !trig_pulse);

    // R8
    pulse_with_flag_chk: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> (triggered && !armed));

    // R2
    arm_effect_chk: assert property (@(posedge clk) disable iff (rst)
        arm |=> (armed && !triggered && !trig_pulse));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!armed && !arm) |=> !trig_pulse);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (triggered && !arm) |=> triggered);

    // R5
    first_no_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (arm_q && edge_en && !arm) |=> !trig_pulse);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!trig_pulse && !triggered && !armed));
endmodule

bind trig_unit trig_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .arm        (arm),
    .edge_en    (edge_en),
    .trig_pulse (trig_pulse),
    .triggered  (triggered),
    .armed      (armed)
);

// File: tb/tb_trig_unit.sv
module tb_trig_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        arm = 1'b0;
    logic [15:0] smp = '0;
    logic [15:0] lvl_mask = '0;
    logic [15:0] lvl_val = '0;
    logic        edge_en = 1'b0;
    logic [3:0]  edge_sel = '0;
    logic [1:0]  edge_pol = '0;
    logic        trig_pulse, triggered, armed;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    trig_unit dut (
        .clk(clk), .rst(rst), .arm(arm), .smp(smp),
        .lvl_mask(lvl_mask), .lvl_val(lvl_val), .edge_en(edge_en),
        .edge_sel(edge_sel), .edge_pol(edge_pol),
        .trig_pulse(trig_pulse), .triggered(triggered), .armed(armed)
    );

    // {arm, smp, mask, val, een, esel, epol, exp_pulse, exp_trig}
    localparam int NV = 21;
    localparam logic [57:0] VEC [NV] = '{
        // R7/R3 levels only: low byte must be 5A
        {1'b1, 16'h005A, 16'h00FF, 16'h005A, 1'b0, 4'd0, 2'b00, 1'b0, 1'b0},
        {1'b0, 16'h0000, 16'h00FF, 16'h005A, 1'b0, 4'd0, 2'b00, 1'b0, 1'b0},
        {1'b0, 16'hFF5A, 16'h00FF, 16'h005A, 1'b0, 4'd0, 2'b00, 1'b1, 1'b1},
        {1'b0, 16'h005A, 16'h00FF, 16'h005A, 1'b0, 4'd0, 2'b00, 1'b0, 1'b1},
        // R6/R4 rising ch5 AND ch0 high
        {1'b1, 16'h0021, 16'h0001, 16'h0001, 1'b1, 4'd5, 2'b00, 1'b0, 1'b0},
        {1'b0, 16'h0021, 16'h0001, 16'h0001, 1'b1, 4'd5, 2'b00, 1'b0, 1'b0},
        {1'b0, 16'h0001, 16'h0001, 16'h0001, 1'b1, 4'd5, 2'b00, 1'b0, 1'b0},
        {1'b0, 16'h0020, 16'h0001, 16'h0001, 1'b1, 4'd5, 2'b00, 1'b0, 1'b0},
        {1'b0, 16'h0001, 16'h0001, 16'h0001, 1'b1, 4'd5, 2'b00, 1'b0, 1'b0},
        {1'b0, 16'h0021, 16'h0001, 16'h0001, 1'b1, 4'd5, 2'b00, 1'b1, 1'b1},
        // R5/R4 falling ch15, arm sample high
        {1'b1, 16'h8000, 16'h0000, 16'h0000, 1'b1, 4'd15, 2'b01, 1'b0, 1'b0},
        {1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b1, 4'd15, 2'b01, 1'b0, 1'b0},
        {1'b0, 16'h8000, 16'h0000, 16'h0000, 1'b1, 4'd15, 2'b01, 1'b0, 1'b0},
        {1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b1, 4'd15, 2'b01, 1'b1, 1'b1},
        // R4 either direction ch0
        {1'b1, 16'h0000, 16'h0000, 16'h0000, 1'b1, 4'd0, 2'b10, 1'b0, 1'b0},
        {1'b0, 16'h0001, 16'h0000, 16'h0000, 1'b1, 4'd0, 2'b10, 1'b0, 1'b0},
        {1'b0, 16'h0001, 16'h0000, 16'h0000, 1'b1, 4'd0, 2'b10, 1'b0, 1'b0},
        {1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b1, 4'd0, 2'b10, 1'b1, 1'b1},
        // R7 nothing enabled, then R9 ignore
        {1'b1, 16'h1234, 16'h0000, 16'h0000, 1'b0, 4'd0, 2'b00, 1'b0, 1'b0},
        {1'b0, 16'h1234, 16'h0000, 16'h0000, 1'b0, 4'd0, 2'b00, 1'b1, 1'b1},
        {1'b0, 16'h1234, 16'h0000, 16'h0000, 1'b0, 4'd0, 2'b00, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic a, input logic [15:0] s);
        @(negedge clk);
        arm = a;
        smp = s;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 pulse", trig_pulse, 1'b0);
        chk("R1 flag", triggered, 1'b0);
        chk("R1 armed", armed, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R9: unarmed, no conditions, no pulse
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 16'hFFFF);
            chk("R9 unarmed", trig_pulse, 1'b0);
        end

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            lvl_mask = VEC[i][40:25];
            lvl_val  = VEC[i][24:9];
            edge_en  = VEC[i][8];
            edge_sel = VEC[i][7:4];
            edge_pol = VEC[i][3:2];
            step(VEC[i][57], VEC[i][56:41]);
            chk($sformatf("R8 vec%0d pulse", i), trig_pulse, VEC[i][1]);
            chk($sformatf("R9 vec%0d flag", i), triggered, VEC[i][0]);
            if (VEC[i][57]) chk($sformatf("R2 vec%0d armed", i), armed, 1'b1);
        end

        // R2/R5: re-arm discards edge history
        @(negedge clk);
        lvl_mask = '0; edge_en = 1'b1; edge_sel = 4'd0; edge_pol = 2'b00;
        step(1'b1, 16'h0000);
        step(1'b0, 16'h0000);
        step(1'b1, 16'h0000);
        step(1'b0, 16'h0001);
        chk("R5 re-arm first sample", trig_pulse, 1'b0);
        step(1'b0, 16'h0000);
        step(1'b0, 16'h0001);
        chk("R4 rise after re-arm", trig_pulse, 1'b1);
        chk("R8 armed drops", armed, 1'b0);
        step(1'b0, 16'h0000);
        chk("R8 pulse one cycle", trig_pulse, 1'b0);
        step(1'b0, 16'h0001);
        chk("R9 no second fire", trig_pulse, 1'b0);

        // R1: reset while triggered
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 flag cleared", triggered, 1'b0);
        chk("R1 armed cleared", armed, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule